// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts processor activity. It has one cycle counter and two event counters. Each event counter can be aimed at any of the event pulse lines that the processor drives. A single control word sets up all three counters. It holds one global run bit, one-shot clear bits, a cycle prescaler bit, three interrupt enables, three sticky overflow flags and two 8-bit event codes. Software reaches the control word and the three counters through a small register port with a two-bit address. Writes take effect at the clock edge, and reads return data in the same cycle.

No counter can be started or stopped on its own. To park a single event counter, software selects code 0x20. That code follows the external event input, which is normally idle, so the counter holds its value. Overflow flags clear when a one is written to them. Software can therefore read the control word and write it straight back, and this acknowledges every flag that was set. When a counter wraps from all ones to zero, it sets its flag and keeps counting. One interrupt line is raised while any flag is set and its enable is on.

The run control is a four-state machine: HALT, RUN, HALT_DIV and RUN_DIV. The states are named after the stored run bit (bit 0) and prescaler bit (bit 3). Every control write takes the transition to the state that these two written bits select. For example, the start transition goes from HALT to RUN and the stop transition goes from RUN to HALT. With no control write, the machine holds its state. Counters advance only in RUN and RUN_DIV, starting with the edge that follows the write that entered the state.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, the control word and all three counters read zero and the interrupt is low.
- R2: Counters advance only while control bit 0 is set. The cycle counter adds one on every clock edge that follows the enabling write, up to and including the edge of the disabling write.
- R3: Event counter 0 takes its code from control bits 27:20 and event counter 1 takes its code from bits 19:12. A code from 0x00 to 0x12 counts the cycles in which the event input line with that index is high.
- R4: Code 0x20 counts the cycles in which the external event input is high. Code 0xFF and any other code with no line wired to it never count.
- R5: Writing the control word with bit 1 set clears both event counters, and with bit 2 set clears the cycle counter and its prescaler. Both bits read back as zero.
- R6: With control bit 3 set, the cycle counter advances once per 64 running cycles. The first advance comes on the 64th running edge after a prescaler clear.
- R7: Address 0 is the control word, address 1 the cycle counter, address 2 event counter 0 and address 3 event counter 1. A counter write stores the written value, and it overrides an increment in the same cycle.
- R8: A counter that wraps from all ones to zero sets its sticky overflow flag and keeps counting. The flags are bit 8 for event counter 0, bit 9 for event counter 1 and bit 10 for the cycle counter.
- R9: Writing a one to an overflow flag bit clears it, and writing a zero leaves it unchanged. Writing back the value just read therefore clears the set flags.
- R10: The interrupt is high exactly when some overflow flag is set together with its enable. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R11: Control bits 1, 2, 7, 11 and 28 to 31 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_LINES | Event pulse lines, indexed by event code |
| ext_evt_i | input | 1 | External event input, selected by code 0x20 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, same cycle |
| irq_o | output | 1 | Shared overflow interrupt |

## Verification
The hardest case to reach is a wrap. From reset, a counter needs more than four billion increments to reach it. The bench instead loads all ones through the register port and then lets one or two events arrive, which gives the wrap, the flag, the interrupt and the count after the wrap within a few cycles. The prescaler boundary needs 64 running cycles. That run starts from a control write that sets the run bit together with the cycle clear bit, so the prescaler phase is known at the start.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int CODE_W   = 8;
    localparam int NUM_CTR  = 3;

    // counter slot order inside the unit, matches flag/enable bit order
    localparam int SLOT_EV0 = 0;
    localparam int SLOT_EV1 = 1;
    localparam int SLOT_CYC = 2;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_CYC  = 2'd1;
    localparam logic [1:0] ADR_EV0  = 2'd2;
    localparam logic [1:0] ADR_EV1  = 2'd3;

    localparam int B_RUN     = 0;
    localparam int B_CLR_EV  = 1;
    localparam int B_CLR_CYC = 2;
    localparam int B_DIV     = 3;
    localparam int B_IEN_LO  = 4;
    localparam int B_FLG_LO  = 8;
    localparam int B_SEL1_LO = 12;
    localparam int B_SEL0_LO = 20;

    localparam logic [CODE_W-1:0] CODE_EXT = 8'h20;

    typedef enum logic [1:0] {
        ST_HALT     = 2'b00,
        ST_RUN      = 2'b01,
        ST_HALT_DIV = 2'b10,
        ST_RUN_DIV  = 2'b11
    } run_state_e;

    function automatic logic [1:0] slot_addr(input int slot);
        case (slot)
            SLOT_EV0: slot_addr = ADR_EV0;
            SLOT_EV1: slot_addr = ADR_EV1;
            default:  slot_addr = ADR_CYC;
        endcase
    endfunction

endpackage

// File: rtl/pmu_evt_select.sv
module pmu_evt_select
    import pmu_pkg::*;
#(
    parameter int NUM_LINES = 19
) (
    input  logic [CODE_W-1:0]    code_i,
    input  logic [NUM_LINES-1:0] evt_i,
    input  logic                 ext_i,
    output logic                 hit_o
);

    logic [NUM_LINES-1:0] match;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign match[i] = (code_i == CODE_W'(i)) && evt_i[i];
    end

    always_comb begin
        hit_o = |match;
        if (code_i == CODE_EXT) begin
            hit_o = ext_i;
        end
    end

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              inc_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic              wrap_o
);

    logic [DATA_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (inc_i) begin
            cnt_q <= cnt_q + DATA_W'(1);
        end
    end

    assign wrap_o = inc_i && !clr_i && !load_i && (cnt_q == '1);
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
    parameter int PRE_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic adv_i,
    output logic tick_o,
    output logic at_last_o
);

    logic [PRE_LOG2-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr_i) begin
            pre_q <= '0;
        end else if (adv_i) begin
            pre_q <= pre_q + PRE_LOG2'(1);
        end
    end

    assign at_last_o = (pre_q == '1);
    assign tick_o    = adv_i && at_last_o;

endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
    import pmu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               wr_run_i,
    input  logic               wr_div_i,
    input  logic [NUM_CTR-1:0] wr_ien_i,
    input  logic [NUM_CTR-1:0] wr_ack_i,
    input  logic [CODE_W-1:0]  wr_sel0_i,
    input  logic [CODE_W-1:0]  wr_sel1_i,
    input  logic [NUM_CTR-1:0] wrap_i,
    output logic               running_o,
    output logic               div_mode_o,
    output logic [NUM_CTR-1:0] ien_o,
    output logic [NUM_CTR-1:0] flag_o,
    output logic [CODE_W-1:0]  sel0_o,
    output logic [CODE_W-1:0]  sel1_o
);

    run_state_e state_q, state_d;
    logic [NUM_CTR-1:0] ien_q, flag_q, flag_d;
    logic [CODE_W-1:0]  sel0_q, sel1_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: every control write jumps to the state its run/div bits name
    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            unique case ({wr_div_i, wr_run_i})
                2'b00: state_d = ST_HALT;
                2'b01: state_d = ST_RUN;
                2'b10: state_d = ST_HALT_DIV;
                2'b11: state_d = ST_RUN_DIV;
            endcase
        end
    end

    // state outputs
    always_comb begin
        unique case (state_q)
            ST_HALT:     begin running_o = 1'b0; div_mode_o = 1'b0; end
            ST_RUN:      begin running_o = 1'b1; div_mode_o = 1'b0; end
            ST_HALT_DIV: begin running_o = 1'b0; div_mode_o = 1'b1; end
            ST_RUN_DIV:  begin running_o = 1'b1; div_mode_o = 1'b1; end
        endcase
    end

    // sticky flags: a wrap wins over an acknowledge in the same cycle
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_flag
        assign flag_d[i] = wrap_i[i] || (flag_q[i] && !(wr_i && wr_ack_i[i]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= '0;
            flag_q <= '0;
            sel0_q <= '0;
            sel1_q <= '0;
        end else begin
            flag_q <= flag_d;
            if (wr_i) begin
                ien_q  <= wr_ien_i;
                sel0_q <= wr_sel0_i;
                sel1_q <= wr_sel1_i;
            end
        end
    end

    assign ien_o  = ien_q;
    assign flag_o = flag_q;
    assign sel0_o = sel0_q;
    assign sel1_o = sel1_q;

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
    import pmu_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_LINES = 19,
    parameter int PRE_LOG2  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] evt_i,
    input  logic                 ext_evt_i,
    input  logic                 reg_we_i,
    input  logic [1:0]           reg_addr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    output logic                 irq_o
);

    logic                            ctrl_wr;
    logic                            running, div_mode;
    logic [NUM_CTR-1:0]              ien, flag, wrap, inc, clr, load;
    logic [CODE_W-1:0]               sel0, sel1;
    logic [1:0][CODE_W-1:0]          sel;
    logic [1:0]                      ev_hit;
    logic [NUM_CTR-1:0][DATA_W-1:0]  cnt;
    logic                            pre_tick, pre_last;
    logic [DATA_W-1:0]               ctrl_word;

    assign ctrl_wr = reg_we_i && (reg_addr_i == ADR_CTRL);

    pmu_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (ctrl_wr),
        .wr_run_i   (reg_wdata_i[B_RUN]),
        .wr_div_i   (reg_wdata_i[B_DIV]),
        .wr_ien_i   (reg_wdata_i[B_IEN_LO +: NUM_CTR]),
        .wr_ack_i   (reg_wdata_i[B_FLG_LO +: NUM_CTR]),
        .wr_sel0_i  (reg_wdata_i[B_SEL0_LO +: CODE_W]),
        .wr_sel1_i  (reg_wdata_i[B_SEL1_LO +: CODE_W]),
        .wrap_i     (wrap),
        .running_o  (running),
        .div_mode_o (div_mode),
        .ien_o      (ien),
        .flag_o     (flag),
        .sel0_o     (sel0),
        .sel1_o     (sel1)
    );

    assign sel[0] = sel0;
    assign sel[1] = sel1;

    for (genvar e = 0; e < 2; e++) begin : g_sel
        pmu_evt_select #(.NUM_LINES(NUM_LINES)) u_sel (
            .code_i (sel[e]),
            .evt_i  (evt_i),
            .ext_i  (ext_evt_i),
            .hit_o  (ev_hit[e])
        );
    end

    pmu_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr[SLOT_CYC]),
        .adv_i     (running && div_mode),
        .tick_o    (pre_tick),
        .at_last_o (pre_last)
    );

    assign clr[SLOT_EV0] = ctrl_wr && reg_wdata_i[B_CLR_EV];
    assign clr[SLOT_EV1] = ctrl_wr && reg_wdata_i[B_CLR_EV];
    assign clr[SLOT_CYC] = ctrl_wr && reg_wdata_i[B_CLR_CYC];

    assign inc[SLOT_EV0] = running && ev_hit[0];
    assign inc[SLOT_EV1] = running && ev_hit[1];
    assign inc[SLOT_CYC] = running && (div_mode ? pre_tick : 1'b1);

    for (genvar s = 0; s < NUM_CTR; s++) begin : g_ctr
        assign load[s] = reg_we_i && (reg_addr_i == slot_addr(s));
        pmu_counter #(.DATA_W(DATA_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr_i      (clr[s]),
            .load_i     (load[s]),
            .load_val_i (reg_wdata_i),
            .inc_i      (inc[s]),
            .cnt_o      (cnt[s]),
            .wrap_o     (wrap[s])
        );
    end

    always_comb begin
        ctrl_word                               = '0;
        ctrl_word[B_RUN]                        = running;
        ctrl_word[B_DIV]                        = div_mode;
        ctrl_word[B_IEN_LO +: NUM_CTR]          = ien;
        ctrl_word[B_FLG_LO +: NUM_CTR]          = flag;
        ctrl_word[B_SEL1_LO +: CODE_W]          = sel1;
        ctrl_word[B_SEL0_LO +: CODE_W]          = sel0;
    end

    always_comb begin
        unique case (reg_addr_i)
            ADR_CTRL: reg_rdata_o = ctrl_word;
            ADR_CYC:  reg_rdata_o = cnt[SLOT_CYC];
            ADR_EV0:  reg_rdata_o = cnt[SLOT_EV0];
            ADR_EV1:  reg_rdata_o = cnt[SLOT_EV1];
        endcase
    end

    assign irq_o = |(flag & ien);

endmodule

// File: rtl/pmu_chk.sv
module pmu_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              running,
    input logic              div_mode,
    input logic              pre_last,
    input logic              reg_we,
    input logic              ctrl_wr,
    input logic              ack_ev0,
    input logic              ev0_hit,
    input logic [2:0]        flag,
    input logic [2:0]        ien,
    input logic              irq,
    input logic [DATA_W-1:0] ev0,
    input logic [DATA_W-1:0] ev1,
    input logic [DATA_W-1:0] cyc
);

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !reg_we) |=> ($stable(ev0) && $stable(ev1) && $stable(cyc)));

    // R3
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ((ev0 == $past(ev0)) || (ev0 == $past(ev0) + DATA_W'(1))));

    // R6
    div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && div_mode && !pre_last && !reg_we) |=> $stable(cyc));

    // R8
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ev0_hit && (ev0 == '1) && !reg_we) |=> (flag[0] && (ev0 == '0)));

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[0] && !(ctrl_wr && ack_ev0)) |=> flag[0]);

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flag & ien) != 3'b000));

endmodule

bind perf_mon_unit pmu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .running  (running),
    .div_mode (div_mode),
    .pre_last (pre_last),
    .reg_we   (reg_we_i),
    .ctrl_wr  (ctrl_wr),
    .ack_ev0  (reg_wdata_i[8]),
    .ev0_hit  (ev_hit[0]),
    .flag     (flag),
    .ien      (ien),
    .irq      (irq_o),
    .ev0      (cnt[0]),
    .ev1      (cnt[1]),
    .cyc      (cnt[2])
);

// File: tb/perf_mon_unit_test.sv
module perf_mon_unit_test;

    localparam int NL = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] evt = '0;
    logic          ext_evt = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    perf_mon_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .ext_evt_i   (ext_evt),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [NL-1:0] m, input int n);
        evt = m;
        repeat (n) @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 register zero after reset", v, 32'h0);
        end
        chk("R1 irq low after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_select;
        logic [31:0] v;
        wr(2'd0, 32'h1 | (32'h03 << 20) | (32'h05 << 12));
        pulse(NL'((1 << 3) | (1 << 5)), 2);
        pulse(NL'(1 << 3), 3);
        idle(1);
        wr(2'd0, 32'h0);
        rd(2'd2, v); chk("R3 event counter 0 on line 3", v, 32'd5);
        rd(2'd3, v); chk("R3 event counter 1 on line 5", v, 32'd2);
        rd(2'd1, v); chk("R2 cycle count over run window", v, 32'd7);
        pulse('1, 4);
        rd(2'd2, v); chk("R2 halted event counter holds", v, 32'd5);
        rd(2'd1, v); chk("R2 halted cycle counter holds", v, 32'd7);
    endtask

    task automatic t_codes;
        logic [31:0] v;
        wr(2'd2, 32'h0);
        wr(2'd3, 32'h0);
        wr(2'd0, 32'h1 | (32'h20 << 20) | (32'hFF << 12));
        pulse('1, 4);
        rd(2'd2, v); chk("R4 code 0x20 idle while external low", v, 32'd0);
        ext_evt = 1'b1;
        idle(3);
        ext_evt = 1'b0;
        wr(2'd0, 32'h0);
        rd(2'd2, v); chk("R4 code 0x20 follows external input", v, 32'd3);
        rd(2'd3, v); chk("R4 code 0xFF never counts", v, 32'd0);
        wr(2'd0, 32'h1 | (32'h13 << 12));
        pulse('1, 3);
        wr(2'd0, 32'h0);
        rd(2'd3, v); chk("R4 unwired code 0x13 never counts", v, 32'd0);
    endtask

    task automatic t_clear_bits;
        logic [31:0] v, cyc_before;
        rd(2'd1, cyc_before);
        wr(2'd0, 32'h2);
        rd(2'd2, v); chk("R5 bit 1 clears event counter 0", v, 32'd0);
        rd(2'd1, v); chk("R5 bit 1 leaves cycle counter", v, cyc_before);
        rd(2'd0, v); chk("R5 clear bits read zero", v, 32'h0);
        wr(2'd0, 32'h4);
        rd(2'd1, v); chk("R5 bit 2 clears cycle counter", v, 32'd0);
    endtask

    task automatic t_prescale;
        logic [31:0] v;
        wr(2'd0, 32'h1 | 32'h8 | 32'h4);
        idle(130);
        wr(2'd0, 32'h8);
        rd(2'd1, v); chk("R6 prescaled cycle count after 131 edges", v, 32'd2);
        rd(2'd0, v); chk("R11 control reads div only", v, 32'h8);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_access;
        logic [31:0] v;
        wr(2'd1, 32'h1234_5678);
        wr(2'd2, 32'hCAFE_0001);
        wr(2'd3, 32'h0BAD_F00D);
        rd(2'd1, v); chk("R7 cycle counter at address 1", v, 32'h1234_5678);
        rd(2'd2, v); chk("R7 event counter 0 at address 2", v, 32'hCAFE_0001);
        rd(2'd3, v); chk("R7 event counter 1 at address 3", v, 32'h0BAD_F00D);
        evt = NL'(1 << 3);
        wr(2'd0, 32'h1 | (32'h03 << 20));
        wr(2'd2, 32'd100);
        wr(2'd0, 32'h0);
        evt = '0;
        rd(2'd2, v); chk("R7 write overrides increment", v, 32'd101);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd0, 32'h1 | 32'h10 | (32'h03 << 20));
        pulse(NL'(1 << 3), 2);
        wr(2'd0, 32'h10 | (32'h03 << 20));
        rd(2'd2, v); chk("R8 counting continues after wrap", v, 32'd1);
        rd(2'd0, v); chk("R8 flag bit 8 set on wrap", v, 32'h0030_0110);
        chk("R10 irq with flag and enable", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h0030_0010);
        rd(2'd0, v); chk("R9 writing zero keeps flag", v, 32'h0030_0110);
        wr(2'd0, 32'h0030_0110);
        rd(2'd0, v); chk("R9 write back clears flag", v, 32'h0030_0010);
        chk("R10 irq drops after acknowledge", {31'b0, irq}, 32'h0);
        wr(2'd3, 32'hFFFF_FFFF);
        wr(2'd0, 32'h1 | 32'h20 | (32'h05 << 12));
        pulse(NL'(1 << 5), 1);
        wr(2'd0, 32'h20);
        rd(2'd0, v); chk("R8 flag bit 9 on event counter 1 wrap", v, 32'h0000_0220);
        chk("R10 irq from event counter 1", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h200);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'h1);
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R8 flag bit 10 on cycle wrap", v, 32'h0000_0400);
        chk("R10 no irq while enable off", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h40);
        chk("R10 irq once cycle enable set", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h400);
        chk("R10 irq low after cycle flag cleared", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_unused;
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R11 undefined bits read zero", v, 32'h0FFF_F079);
        wr(2'd0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select();
        t_codes();
        t_clear_bits();
        t_prescale();
        t_access();
        t_overflow();
        t_unused();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule